// File: doc/BRIEF.md
# Bidirectional Latch-Register Bus Transceiver

This block moves data between two buses, A and B, one direction per path. Each direction has three controls of its own: an output enable, a latch enable and a direction strobe. While its latch enable is high a path is transparent. While it is low the path either keeps its stored word or loads a new one on a rising strobe. The A-to-B enable is active high and the B-to-A enable is active low. Each bit of a direction shares that direction's controls.

The block has no internal tri-state. Each bus side has an input vector, an output data vector and a per-bit drive-enable vector, so a thin pad wrapper can map them onto inout pins. All sequential logic runs on one system clock, `clk_i`. The direction strobes are sampled as data, and a rising strobe is the first `clk_i` edge at which the strobe is seen high after being seen low. An active-low asynchronous reset clears both stored words.

Top module: `bxr_top`

## Requirements
- R1: While `ab_le_i` is 1, `b_o` equals `a_i` in the same cycle, and the stored A-to-B word takes `a_i` at every `clk_i` edge.
- R2: While `ab_le_i` is 0 and no strobe rise is seen, `b_o` keeps the stored word, whatever `a_i` does. This holds with the strobe steady low, and with it steady high when it rose before the latch enable fell. After the latch enable falls, the held word is the `a_i` value at the last `clk_i` edge with `ab_le_i` at 1.
- R3: With `ab_le_i` at 0, a strobe rise of `ab_clk_i` loads `a_i` into storage at the `clk_i` edge where the rise is first seen, and `b_o` shows it right after that edge. One rise gives one load.
- R4: `ab_oe_i` is active high. When it is 0, `b_oe_o` is all zeros and `b_o` is all zeros. When it is 1, `b_oe_o` is all ones.
- R5: `ba_oe_ni` is active low. When it is 1, `a_oe_o` and `a_o` are all zeros. When it is 0, `a_oe_o` is all ones.
- R6: The B-to-A path follows R1 to R3, taking its data from `b_i`, its latch enable from `ba_le_i` and its strobe from `ba_clk_i`, and driving `a_o`.
- R7: Storage loads and tracks even while the output of its direction is disabled. A later enable shows the most recently stored word.
- R8: Reset clears both stored words to zero. With the latch enables at 0 and the outputs enabled, both outputs read zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; samples strobes and updates storage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | WIDTH | Data seen on the A bus |
| b_i | input | WIDTH | Data seen on the B bus |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable, 1 = transparent |
| ba_le_i | input | 1 | B-to-A latch enable, 1 = transparent |
| ab_clk_i | input | 1 | A-to-B load strobe, rising edge loads |
| ba_clk_i | input | 1 | B-to-A load strobe, rising edge loads |
| a_o | output | WIDTH | Data driven onto the A bus |
| a_oe_o | output | WIDTH | Per-bit drive enable for the A bus |
| b_o | output | WIDTH | Data driven onto the B bus |
| b_oe_o | output | WIDTH | Per-bit drive enable for the B bus |

## Verification
The bench builds the block with WIDTH at its default of 18. This makes full-width patterns reachable: all ones, alternating bits, and values that change only in the top or the bottom bit. A bit stuck at the wrong control would show in those patterns. The bench moves each strobe through steady low, rise and steady high around latch enable changes, including the case where the strobe rose before the latch enable fell. It also swaps which side it drives, so that both directions and both enable polarities are covered while it watches for bus contention.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_LOAD = 2'd2
  } bxr_mode_e;

  function automatic bxr_mode_e pick_mode(input logic le, input logic rise);
    if (le)        return MODE_PASS;
    else if (rise) return MODE_LOAD;
    else           return MODE_HOLD;
  endfunction
endpackage

// File: rtl/bxr_edge.sv
module bxr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  AST_RISE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/bxr_store.sv
module bxr_store
  import bxr_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic             rise_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  bxr_mode_e        mode;
  logic [WIDTH-1:0] st_q;

  assign mode = pick_mode(le_i, rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else if (mode != MODE_HOLD) st_q <= d_i;
  end

  // transparent path bypasses storage
  assign q_o = (mode == MODE_PASS) ? d_i : st_q;

  AST_PASS_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (st_q == $past(d_i))); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !rise_i) |=> $stable(st_q)); // R2
  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && rise_i) |=> (st_q == $past(d_i))); // R3
endmodule

// File: rtl/bxr_drive.sv
module bxr_drive #(
  parameter int unsigned WIDTH   = 18,
  parameter bit          ACT_LOW = 1'b0
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] oe_o
);
  logic on;

  if (ACT_LOW) begin : g_low
    assign on = ~en_i;
  end else begin : g_high
    assign on = en_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign q_o[i]  = d_i[i] & on;
    assign oe_o[i] = on;
  end
endmodule

// File: rtl/bxr_dir.sv
module bxr_dir #(
  parameter int unsigned WIDTH      = 18,
  parameter bit          OE_ACT_LOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic             oe_i,
  input  logic             le_i,
  input  logic             stb_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] oe_o
);
  logic             rise;
  logic [WIDTH-1:0] path;

  bxr_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (stb_i),
    .rise_o (rise)
  );

  bxr_store #(.WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .rise_i (rise),
    .d_i    (d_i),
    .q_o    (path)
  );

  bxr_drive #(.WIDTH(WIDTH), .ACT_LOW(OE_ACT_LOW)) u_drive (
    .en_i (oe_i),
    .d_i  (path),
    .q_o  (q_o),
    .oe_o (oe_o)
  );
endmodule

// File: rtl/bxr_top.sv
module bxr_top #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ab_oe_i,
  input  logic             ba_oe_ni,
  input  logic             ab_le_i,
  input  logic             ba_le_i,
  input  logic             ab_clk_i,
  input  logic             ba_clk_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] a_oe_o,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] b_oe_o
);
  bxr_dir #(.WIDTH(WIDTH), .OE_ACT_LOW(1'b0)) u_ab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (a_i),
    .oe_i   (ab_oe_i),
    .le_i   (ab_le_i),
    .stb_i  (ab_clk_i),
    .q_o    (b_o),
    .oe_o   (b_oe_o)
  );

  bxr_dir #(.WIDTH(WIDTH), .OE_ACT_LOW(1'b1)) u_ba (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (b_i),
    .oe_i   (ba_oe_ni),
    .le_i   (ba_le_i),
    .stb_i  (ba_clk_i),
    .q_o    (a_o),
    .oe_o   (a_oe_o)
  );

  AST_AB_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ab_oe_i |-> (b_oe_o == '0 && b_o == '0)); // R4
  AST_BA_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_oe_ni |-> (a_oe_o == '0 && a_o == '0)); // R5
  AST_BA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ba_le_i && !ba_oe_ni) |-> (a_o == b_i)); // R6
  AST_AB_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_le_i && ab_oe_i) |-> (b_o == a_i)); // R1
endmodule

// File: tb/bxr_top_bench.sv
`timescale 1ns/1ps
module bxr_top_bench;
  localparam int W = 18;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         aoe;
    logic         boe;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         ab_oe = 1'b0, ba_oen = 1'b1, ab_le = 1'b0, ba_le = 1'b0;
  logic         ab_clk = 1'b0, ba_clk = 1'b0;
  logic [W-1:0] a_o, a_oe_o, b_o, b_oe_o;
  logic         drv_a = 1'b0, drv_b = 1'b0;

  int n_vec = 0, n_bad = 0;
  exp_t q[$];
  logic [W-1:0] st_ab = '0, st_ba = '0;
  logic         pv_ab = 1'b0, pv_ba = 1'b0;

  always #2.5 clk = ~clk;

  bxr_top #(.WIDTH(W)) u_bxr_top (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_i), .b_i(b_i),
    .ab_oe_i(ab_oe), .ba_oe_ni(ba_oen), .ab_le_i(ab_le), .ba_le_i(ba_le),
    .ab_clk_i(ab_clk), .ba_clk_i(ba_clk),
    .a_o(a_o), .a_oe_o(a_oe_o), .b_o(b_o), .b_oe_o(b_oe_o)
  );

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic aoe, input logic boen,
                      input logic ale, input logic ble,
                      input logic aclk, input logic bclk,
                      input logic da, input logic db, input string req);
    exp_t e;
    logic [W-1:0] nab, nba;
    @(negedge clk);
    a_i = a; b_i = b; ab_oe = aoe; ba_oen = boen; ab_le = ale; ba_le = ble;
    ab_clk = aclk; ba_clk = bclk; drv_a = da; drv_b = db;
    nab = (ale || (aclk && !pv_ab)) ? a : st_ab;
    nba = (ble || (bclk && !pv_ba)) ? b : st_ba;
    st_ab = nab; st_ba = nba; pv_ab = aclk; pv_ba = bclk;
    e.b   = aoe ? (ale ? a : nab) : '0;
    e.boe = aoe;
    e.a   = !boen ? (ble ? b : nba) : '0;
    e.aoe = !boen;
    e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_vec++;
        if (b_o !== e.b || b_oe_o !== {W{e.boe}} ||
            a_o !== e.a || a_oe_o !== {W{e.aoe}}) begin
          n_bad++;
          $display("FAIL %s: a_o=%h a_oe=%h b_o=%h b_oe=%h exp a_o=%h a_oe=%h b_o=%h b_oe=%h",
                   e.req, a_o, a_oe_o, b_o, b_oe_o, e.a, {W{e.aoe}}, e.b, {W{e.boe}});
        end
        if ((drv_a && |a_oe_o) || (drv_b && |b_oe_o)) begin
          n_bad++;
          $display("FAIL R4/R5 contention: a_oe=%h b_oe=%h exp no drive on bench-driven side",
                   a_oe_o, b_oe_o);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state, A-to-B enabled, latch closed
    step(18'h15555, 0, 1, 1, 0, 0, 0, 0, 1, 0, "R8");
    // R1: transparent
    step(18'h3ABCD, 0, 1, 1, 1, 0, 0, 0, 1, 0, "R1");
    step(18'h12345, 0, 1, 1, 1, 0, 0, 0, 1, 0, "R1");
    // R2: latch falls, strobe low
    step(18'h12345, 0, 1, 1, 0, 0, 0, 0, 1, 0, "R2");
    step(18'h0FFFF, 0, 1, 1, 0, 0, 0, 0, 1, 0, "R2");
    // R3: load on strobe rise
    step(18'h2AAAA, 0, 1, 1, 0, 0, 1, 0, 1, 0, "R3");
    step(18'h15555, 0, 1, 1, 0, 0, 1, 0, 1, 0, "R2");
    step(18'h3FFFF, 0, 1, 1, 0, 0, 0, 0, 1, 0, "R2");
    step(18'h00000, 0, 1, 1, 0, 0, 1, 0, 1, 0, "R3");
    step(18'h3FFFF, 0, 1, 1, 0, 0, 0, 0, 1, 0, "R2");
    step(18'h3FFFF, 0, 1, 1, 0, 0, 1, 0, 1, 0, "R3");
    step(18'h20001, 0, 1, 1, 0, 0, 0, 0, 1, 0, "R2");
    // R2: strobe high before latch falls
    step(18'h11111, 0, 1, 1, 1, 0, 1, 0, 1, 0, "R1");
    step(18'h22222, 0, 1, 1, 0, 0, 1, 0, 1, 0, "R2");
    step(18'h33333, 0, 1, 1, 0, 0, 1, 0, 1, 0, "R2");
    // R4 / R7: disabled, storage still loads
    step(18'h2D2D2, 0, 0, 1, 1, 0, 0, 0, 1, 0, "R4");
    step(18'h0F0F0, 0, 0, 1, 0, 0, 0, 0, 1, 0, "R7");
    step(18'h0F0F0, 0, 0, 1, 0, 0, 1, 0, 1, 0, "R7");
    step(18'h30303, 0, 1, 1, 0, 0, 0, 0, 1, 0, "R7");
    // hand over: B-to-A, A side released
    step(0, 18'h1CAFE, 0, 1, 0, 1, 0, 0, 0, 1, "R5");
    step(0, 18'h1CAFE, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
    step(0, 18'h2BEEF, 0, 0, 0, 1, 0, 0, 0, 0, "R6");
    step(0, 18'h00001, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 18'h35A5A, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
    step(0, 18'h0A5A5, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
    step(0, 18'h3FFFF, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 18'h20000, 0, 0, 0, 1, 0, 1, 0, 0, "R6");
    step(0, 18'h00002, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
    // R5 / R7 on B-to-A
    step(0, 18'h12121, 0, 1, 0, 0, 0, 0, 0, 1, "R5");
    step(0, 18'h12121, 0, 1, 0, 0, 0, 1, 0, 1, "R7");
    step(0, 18'h00000, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule